// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Range Status

This block multiplies two single-precision binary floating-point operands (1 sign bit, 8-bit biased exponent with bias 127, 23-bit fraction) and returns a single-precision product together with a two-bit range status. Each operand's implied leading one is attached to its fraction, the two 24-bit significands are multiplied with a plain integer multiply, and the 48-bit result is normalized in a single step. The fraction is then truncated, not rounded, so no second normalization pass is ever needed.

The biased exponents are added and the bias is removed in a signed intermediate wide enough to show results that are too large or too small for the 8-bit field. An exponent that is too large gives a signed infinity pattern with status overflow. An exponent that is too small gives a signed zero with status underflow. In both cases the sign is computed as for any other result. The result and status are registered, and the output strobe follows the input strobe by one clock.

Operands are expected to be normal numbers. Zeros, denormals, infinities and NaNs at the inputs are outside the intended use.

Top module: `fp_mul_range`

## Requirements
- R1: The product sign bit (bit 31) is the XOR of the two operand sign bits, for normal, overflowed and underflowed results alike.
- R2: For a normal result, the product exponent field (bits 30:23) equals ea + eb − 127, plus one when the significand product is 2.0 or more. Here ea and eb are the operand exponent fields (bits 30:23).
- R3: Each significand is formed as a leading one followed by the operand's 23-bit fraction (bits 22:0). If the 48-bit product of the significands has bit 47 set, it is shifted right by one. The result fraction is the 23 bits directly below the leading one, and the bits below them are dropped without rounding.
- R4: If the final exponent is 255 or more, status is 2'b01, the exponent field is 8'hFF and the fraction field is zero.
- R5: If the final exponent is 0 or less, status is 2'b10, and both the exponent and fraction fields are zero.
- R6: Status is 2'b00 for an in-range result. The code 2'b11 never appears.
- R7: Product and status are registered on the clock edge at which in_valid is high. out_valid is high exactly in the cycle after in_valid was high.
- R8: While in_valid is low, product and status keep their last values, whatever the operand inputs do.
- R9: After reset, out_valid is 0, product is 32'h0 and status is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | Product and status are fresh |
| product | output | 32 | Truncated single-precision product |
| status | output | 2 | 00 normal, 01 overflow, 10 underflow |

## Verification
The hardest cases are the ones where the normalization carry alone decides the range outcome. An exponent sum that lands exactly on 254 becomes 255, and therefore overflow, only when both significands are large enough that their product reaches 2.0. One less in the sum, or a product below 2.0, must stay in range. Random operands almost never reach these edges. The stimulus therefore places directed operand pairs at exponent totals of 254 and 255 and at 0 and 1, each with and without the carry. Random pairs with biased exponents drawn over the whole normal range then cover the middle of the range and both clamp regions.

// File: rtl/fp_mul_range.sv
module fp_mul_range #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     product,
  output logic [1:0]                status
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXT_W  = EXP_W + 2;
  localparam logic [EXT_W-1:0] BIAS    = EXT_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [EXT_W-1:0] EXP_TOP = EXT_W'((1 << EXP_W) - 1);

  logic              sign_r;
  logic [SIG_W-1:0]  sig_a, sig_b;
  logic [PROD_W-1:0] sig_p;
  logic              carry;
  logic [FRAC_W-1:0] frac_n;
  logic signed [EXT_W-1:0] exp_n;
  logic              ovf, unf;
  logic [WORD_W-1:0] result;
  logic [1:0]        code;

  assign sign_r = op_a[WORD_W-1] ^ op_b[WORD_W-1];
  assign sig_a  = {1'b1, op_a[FRAC_W-1:0]};
  assign sig_b  = {1'b1, op_b[FRAC_W-1:0]};
  assign sig_p  = sig_a * sig_b;
  assign carry  = sig_p[PROD_W-1];
  assign frac_n = carry ? sig_p[PROD_W-2 -: FRAC_W] : sig_p[PROD_W-3 -: FRAC_W];

  assign exp_n = $signed({2'b00, op_a[WORD_W-2:FRAC_W]} + {2'b00, op_b[WORD_W-2:FRAC_W]}
                         - BIAS + {{(EXT_W-1){1'b0}}, carry});

  assign ovf = exp_n >= $signed(EXP_TOP);
  assign unf = exp_n <= $signed({EXT_W{1'b0}});

  always_comb begin
    if (ovf) begin
      result = {sign_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      code   = 2'b01;
    end else if (unf) begin
      result = {sign_r, {(WORD_W-1){1'b0}}};
      code   = 2'b10;
    end else begin
      result = {sign_r, exp_n[EXP_W-1:0], frac_n};
      code   = 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
      status    <= 2'b00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        product <= result;
        status  <= code;
      end
    end
  end
endmodule

// File: rtl/fp_mul_range_chk.sv
module fp_mul_range_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        out_valid,
  input logic [31:0] product,
  input logic [1:0]  status
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> product[31] == $past(op_a[31] ^ op_b[31]));
  a_r4_overflow_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'b01 |-> product[30:0] == {8'hFF, 23'h0});
  a_r5_underflow_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'b10 |-> product[30:0] == 31'h0);
  a_r6_no_code_11: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product) && $stable(status));
endmodule

bind fp_mul_range fp_mul_range_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .product(product), .status(status)
);

// File: tb/test_fp_mul_range.sv
module test_fp_mul_range;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [31:0] product;
  logic [1:0] status;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_mul_range i_fp_mul_range (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product), .status(status)
  );

  function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
    longint unsigned ma, mb, m;
    int e;
    logic s;
    ma = 64'h80_0000 | longint'(a[22:0]);
    mb = 64'h80_0000 | longint'(b[22:0]);
    m  = ma * mb;
    e  = int'(a[30:23]) + int'(b[30:23]) - 127;
    s  = a[31] ^ b[31];
    while (m >= (64'd1 << 47)) begin
      m = m >> 1;
      e = e + 1;
    end
    if (e >= 255) return {2'b01, s, 8'hFF, 23'h0};
    if (e <= 0)   return {2'b10, s, 31'h0};
    return {2'b00, s, e[7:0], m[45:23]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got_p, input logic [1:0] got_s,
                       input logic [31:0] exp_p, input logic [1:0] exp_s);
    tests++;
    if (got_p !== exp_p || got_s !== exp_s) begin
      fails++;
      $display("FAIL %s: product=%h status=%b expected product=%h status=%b",
               tag, got_p, got_s, exp_p, exp_s);
    end
  endtask

  task automatic mul(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] exp_p, input logic [1:0] exp_s);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    tests++;
    if (out_valid !== 1'b1) begin
      fails++;
      $display("FAIL R7 %s: out_valid=%b expected 1", tag, out_valid);
    end
    check(tag, product, status, exp_p, exp_s);
  endtask

  task automatic mul_model(input string tag, input logic [31:0] a, input logic [31:0] b);
    logic [33:0] r;
    r = model(a, b);
    mul(tag, a, b, r[31:0], r[33:32]);
  endtask

  function automatic logic [31:0] rnd_op();
    logic [31:0] v;
    v = $urandom;
    v[30:23] = 8'($urandom_range(1, 254));
    return v;
  endfunction

  initial begin
    void'($urandom(32'd2718));
    #3;
    tests++;
    if (out_valid !== 1'b0 || product !== 32'h0 || status !== 2'b00) begin
      fails++;
      $display("FAIL R9 reset: valid=%b product=%h status=%b expected 0 0 00",
               out_valid, product, status);
    end
    @(negedge clk); rst_n = 1'b1;

    mul("R2 exp sum 137+123-127", 32'h4480_0000, 32'h3D80_0000, 32'h4280_0000, 2'b00);
    mul("R1 R2 neg times pos", 32'hBF80_0000, 32'h4000_0000, 32'hC000_0000, 2'b00);
    mul("R3 carry 1.5*1.5", 32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 2'b00);
    mul("R3 truncation max sig", 32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFE, 2'b00);
    mul_model("R3 case a", 32'hC4DB_5AD7, 32'h3DE0_0000);
    mul("R5 R1 case b", 32'h0FDB_5AD7, 32'h9AE0_0000, 32'h8000_0000, 2'b10);
    mul("R4 R1 case c", 32'hDB5B_5AD7, 32'hE3E0_0000, 32'h7F80_0000, 2'b01);
    mul("R6 top edge 254", 32'h7F00_0000, 32'h3F80_0000, 32'h7F00_0000, 2'b00);
    mul("R4 carry to 255", 32'h7F40_0000, 32'h3FC0_0000, 32'h7F80_0000, 2'b01);
    mul("R6 low edge 1", 32'h0080_0000, 32'h3F80_0000, 32'h0080_0000, 2'b00);
    mul("R5 exact zero exp", 32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, 2'b10);
    mul("R5 carry rescues to 1", 32'h00C0_0000, 32'h3F40_0000, 32'h0090_0000, 2'b00);

    @(negedge clk);
    op_a = 32'h7F7F_FFFF; op_b = 32'h7F7F_FFFF;
    @(negedge clk);
    check("R8 hold without strobe", product, status, 32'h0090_0000, 2'b00);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R7 idle: out_valid=%b expected 0", out_valid);
    end

    for (int i = 0; i < 300; i++) mul_model("R1 R2 R3 R4 R5 random", rnd_op(), rnd_op());
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule